// File: doc/BRIEF.md
# Camera Capture Flow Controller

This block decides, frame by frame, whether pixel data from a camera-style parallel port is allowed through to the stage that writes it to memory. Frame boundaries arrive as single-cycle start and end pulses that have already been decoded. The block holds a small control word: a request bit, a mode bit that selects continuous or single-frame capture, and a rate field that divides the frame rate. From these it produces a per-frame pass enable, a capture-active flag, a hardware clear of the request bit, and pulses that mark the first and last cycle of every frame that is passed.

A capture never begins part-way through a frame. Once the request is seen, the block waits for the next frame start. In single-frame mode it passes exactly one frame and clears the request itself. In continuous mode it keeps capturing, thinned out by the rate field, until software withdraws the request. When the request is withdrawn, the frame in progress is allowed to finish.

Top module: `cam_flow_ctrl`

## Requirements
- R1: A capture begins only when a frame-start pulse is sampled while pipe_en is 1 and the request bit is 1. No frame is passed while pipe_en is 0, even when the request bit is set.
- R2: When a capture begins, cap_active, pass_en and the one-cycle cap_start pulse are all 1 in the cycle after the frame-start pulse.
- R3: In single-frame mode (cfg_mode = 1), the request bit reads 0 and req_clr pulses for one cycle in the cycle after the frame start that begins the capture.
- R4: In single-frame mode exactly one frame is passed, whatever the rate field holds. cap_active is 0 in the cycle after that frame's end pulse.
- R5: In continuous mode (cfg_mode = 0), cap_active stays 1 across frame boundaries for as long as the request bit stays 1.
- R6: In continuous mode the k-th frame of a capture (k = 0 is the first) is passed exactly when k mod 2^rate = 0. Rate 0 passes every frame, 1 passes one in two, 2 one in four, and 3 one in eight.
- R7: When software clears the request bit during a continuous capture, the current frame keeps its pass decision until its end pulse. cap_active is 0 in the cycle after that end, and later frames are not passed.
- R8: A request written in the middle of a frame has no effect on that frame: pass_en and cap_active stay 0 until the next frame start.
- R9: A cycle with pipe_en at 0 forces cap_active and pass_en to 0 in the following cycle, so the rest of the frame is dropped.
- R10: pass_en changes only in the cycle after a frame-start or frame-end pulse, or after pipe_en goes low. pass_en is 0 in the cycle after a frame end, and cap_end pulses in that cycle only if the frame was passed.
- R11: After reset, the request bit, cap_active, pass_en and all pulse outputs are 0, and the frame counter restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pipe_en | input | 1 | Pipe enable; 0 aborts any capture |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| frame_end | input | 1 | One-cycle pulse at the end of a frame |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_req | input | 1 | Request bit value to write |
| cfg_mode | input | 1 | Mode to write: 0 continuous, 1 single frame |
| cfg_rate | input | RATE_W | Rate field to write (pass one in 2^rate frames) |
| req_bit | output | 1 | Current request bit |
| req_clr | output | 1 | One-cycle pulse when hardware clears the request |
| cap_active | output | 1 | Capture in progress |
| pass_en | output | 1 | Current frame is to be forwarded |
| cap_start | output | 1 | One-cycle pulse at the start of a passed frame |
| cap_end | output | 1 | One-cycle pulse at the end of a passed frame |

## Verification
The assertions assume clean framing: frame-start and frame-end pulses last one cycle, they alternate, they never arrive in the same cycle, and a software write never lands in the same cycle as a frame start. The bench keeps to these rules. It drives every boundary and every configuration write from a single task sequence on the falling clock edge. Each frame has a fixed body length, and request changes and pipe-enable drops are placed only inside a frame body, between its two boundary pulses.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
   typedef enum logic {
      MODE_CONT   = 1'b0,
      MODE_SINGLE = 1'b1
   } cap_mode_e;

   function automatic int unsigned cnt_width(input int unsigned rate_w);
      return (1 << rate_w) - 1;
   endfunction
endpackage

// File: rtl/cfc_ctrl_reg.sv
module cfc_ctrl_reg
   import cfc_pkg::*;
#(
   parameter int unsigned RATE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_req,
   input  logic              wr_mode,
   input  logic [RATE_W-1:0] wr_rate,
   input  logic              hw_clr,
   output logic              req_q,
   output cap_mode_e         mode_q,
   output logic [RATE_W-1:0] rate_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         mode_q <= MODE_CONT;
         rate_q <= '0;
      end else if (wr_en) begin
         req_q  <= wr_req;
         mode_q <= cap_mode_e'(wr_mode);
         rate_q <= wr_rate;
      end else if (hw_clr) begin
         req_q  <= 1'b0;
      end
   end
endmodule

// File: rtl/cfc_decim.sv
module cfc_decim
   import cfc_pkg::*;
#(
   parameter int unsigned RATE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              advance,
   input  logic              flush,
   input  logic [RATE_W-1:0] rate,
   output logic              hit
);
   localparam int unsigned CNT_W = cnt_width(RATE_W);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] mask;

   generate
      for (genvar b = 0; b < CNT_W; b++) begin : g_mask
         assign mask[b] = (int'(rate) > b);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= CNT_W'(1);
      end else if (advance) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign hit = ((cnt_q & mask) == '0);
endmodule

// File: rtl/cfc_flow_fsm.sv
module cfc_flow_fsm
   import cfc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pipe_en,
   input  logic      frame_start,
   input  logic      frame_end,
   input  logic      req,
   input  cap_mode_e mode,
   input  logic      hit,
   output logic      active,
   output logic      pass,
   output logic      start_p,
   output logic      end_p,
   output logic      clr_p,
   output logic      hw_clr,
   output logic      restart,
   output logic      advance,
   output logic      flush
);
   logic active_q, pass_q, single_q;
   logic begin_cap, cont_frame, stop_at_fs;

   always_comb begin
      begin_cap  = pipe_en && frame_start && !active_q && req;
      cont_frame = pipe_en && frame_start && active_q && !single_q && req;
      stop_at_fs = pipe_en && frame_start && active_q && !req;
      hw_clr     = begin_cap && (mode == MODE_SINGLE);
      restart    = begin_cap;
      advance    = cont_frame;
      flush      = !pipe_en;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !pipe_en) begin
         active_q <= 1'b0;
         pass_q   <= 1'b0;
         single_q <= 1'b0;
         start_p  <= 1'b0;
         end_p    <= 1'b0;
         clr_p    <= 1'b0;
      end else begin
         start_p <= 1'b0;
         end_p   <= 1'b0;
         clr_p   <= hw_clr;
         if (begin_cap) begin
            active_q <= 1'b1;
            single_q <= (mode == MODE_SINGLE);
            pass_q   <= 1'b1;
            start_p  <= 1'b1;
         end else if (cont_frame) begin
            pass_q  <= hit;
            start_p <= hit;
         end else if (stop_at_fs) begin
            active_q <= 1'b0;
            pass_q   <= 1'b0;
         end
         if (frame_end && active_q) begin
            pass_q <= 1'b0;
            end_p  <= pass_q;
            if (single_q || !req) begin
               active_q <= 1'b0;
            end
         end
      end
   end

   assign active = active_q;
   assign pass   = pass_q;
endmodule

// File: rtl/cam_flow_ctrl.sv
module cam_flow_ctrl
   import cfc_pkg::*;
#(
   parameter int unsigned RATE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pipe_en,
   input  logic              frame_start,
   input  logic              frame_end,
   input  logic              cfg_wr,
   input  logic              cfg_req,
   input  logic              cfg_mode,
   input  logic [RATE_W-1:0] cfg_rate,
   output logic              req_bit,
   output logic              req_clr,
   output logic              cap_active,
   output logic              pass_en,
   output logic              cap_start,
   output logic              cap_end
);
   generate
      if (RATE_W < 1 || RATE_W > 3) begin : g_bad_rate_w
         $error("cam_flow_ctrl: RATE_W must be in 1..3");
      end
   endgenerate

   cap_mode_e         mode_q;
   logic [RATE_W-1:0] rate_q;
   logic              hw_clr, restart, advance, flush, hit;

   cfc_ctrl_reg #(.RATE_W(RATE_W)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr),
      .wr_req  (cfg_req),
      .wr_mode (cfg_mode),
      .wr_rate (cfg_rate),
      .hw_clr  (hw_clr),
      .req_q   (req_bit),
      .mode_q  (mode_q),
      .rate_q  (rate_q)
   );

   cfc_decim #(.RATE_W(RATE_W)) u_decim (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .advance (advance),
      .flush   (flush),
      .rate    (rate_q),
      .hit     (hit)
   );

   cfc_flow_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .pipe_en     (pipe_en),
      .frame_start (frame_start),
      .frame_end   (frame_end),
      .req         (req_bit),
      .mode        (mode_q),
      .hit         (hit),
      .active      (cap_active),
      .pass        (pass_en),
      .start_p     (cap_start),
      .end_p       (cap_end),
      .clr_p       (req_clr),
      .hw_clr      (hw_clr),
      .restart     (restart),
      .advance     (advance),
      .flush       (flush)
   );
endmodule

// File: rtl/cfc_checker.sv
module cfc_checker (
   input logic clk,
   input logic rst_n,
   input logic pipe_en,
   input logic frame_start,
   input logic frame_end,
   input logic req_clr,
   input logic cap_active,
   input logic pass_en,
   input logic cap_start,
   input logic cap_end
);
   p_begin_on_fs_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_active) |-> $past(frame_start));

   p_pass_needs_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pass_en |-> cap_active);

   p_start_has_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cap_start |-> pass_en);

   p_clr_on_fs_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_clr |-> $past(frame_start));

   p_pipe_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !pipe_en |=> (!cap_active && !pass_en));

   p_pass_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_en && !frame_start && !frame_end) |=> $stable(pass_en));

   p_end_after_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cap_end |-> ($past(frame_end) && $past(pass_en)));

   p_fe_drops_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> !pass_en);
endmodule

bind cam_flow_ctrl cfc_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pipe_en     (pipe_en),
   .frame_start (frame_start),
   .frame_end   (frame_end),
   .req_clr     (req_clr),
   .cap_active  (cap_active),
   .pass_en     (pass_en),
   .cap_start   (cap_start),
   .cap_end     (cap_end)
);

// File: tb/cam_flow_ctrl_test.sv
`timescale 1ns/1ps
module cam_flow_ctrl_test;
   localparam int RATE_W = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pipe_en = 1'b0;
   logic frame_start = 1'b0;
   logic frame_end = 1'b0;
   logic cfg_wr = 1'b0;
   logic cfg_req = 1'b0;
   logic cfg_mode = 1'b0;
   logic [RATE_W-1:0] cfg_rate = '0;
   logic req_bit, req_clr, cap_active, pass_en, cap_start, cap_end;

   int vectors = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   cam_flow_ctrl #(.RATE_W(RATE_W)) uut (
      .clk(clk), .rst_n(rst_n), .pipe_en(pipe_en),
      .frame_start(frame_start), .frame_end(frame_end),
      .cfg_wr(cfg_wr), .cfg_req(cfg_req), .cfg_mode(cfg_mode), .cfg_rate(cfg_rate),
      .req_bit(req_bit), .req_clr(req_clr), .cap_active(cap_active),
      .pass_en(pass_en), .cap_start(cap_start), .cap_end(cap_end)
   );

   task automatic check(input string tag, input logic act, input logic exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic write_cfg(input logic rq, input logic md, input int rt);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_req = rq; cfg_mode = md; cfg_rate = RATE_W'(rt);
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic fstart();
      @(negedge clk); frame_start = 1'b1;
      @(negedge clk); frame_start = 1'b0;
   endtask

   task automatic fend();
      @(negedge clk); frame_end = 1'b1;
      @(negedge clk); frame_end = 1'b0;
   endtask

   task automatic body();
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 reset pass_en", pass_en, 1'b0);
      check("R11 reset cap_active", cap_active, 1'b0);
      check("R11 reset req_bit", req_bit, 1'b0);
      check("R11 reset cap_start", cap_start, 1'b0);

      // R1: request set but pipe disabled
      write_cfg(1'b1, 1'b0, 0);
      fstart();
      check("R1 no pass without pipe_en", pass_en, 1'b0);
      check("R1 inactive without pipe_en", cap_active, 1'b0);
      body(); fend();
      write_cfg(1'b0, 1'b0, 0);
      pipe_en = 1'b1;

      // R5 R6 R7: continuous sweep over every rate
      for (int r = 0; r < 4; r++) begin
         write_cfg(1'b1, 1'b0, r);
         for (int k = 0; k < 16; k++) begin
            logic ep;
            ep = ((k % (1 << r)) == 0);
            fstart();
            check($sformatf("R6 rate %0d frame %0d pass", r, k), pass_en, ep);
            check($sformatf("R2 rate %0d frame %0d start", r, k), cap_start, ep);
            check($sformatf("R5 rate %0d frame %0d active", r, k), cap_active, 1'b1);
            body();
            check($sformatf("R10 rate %0d frame %0d hold", r, k), pass_en, ep);
            fend();
            check($sformatf("R10 rate %0d frame %0d drop", r, k), pass_en, 1'b0);
            check($sformatf("R10 rate %0d frame %0d end", r, k), cap_end, ep);
            check($sformatf("R5 rate %0d frame %0d stays", r, k), cap_active, 1'b1);
         end
         // frame 16 is always passed; clear the request inside it
         fstart();
         check("R6 frame 16 pass", pass_en, 1'b1);
         write_cfg(1'b0, 1'b0, r);
         body();
         check("R7 current frame kept", pass_en, 1'b1);
         check("R7 still active", cap_active, 1'b1);
         fend();
         check("R7 end pulse", cap_end, 1'b1);
         check("R7 active cleared", cap_active, 1'b0);
         fstart();
         check("R7 next frame dropped", pass_en, 1'b0);
         body(); fend();
      end

      // R3 R4: single-frame mode under every rate value
      for (int r = 0; r < 4; r++) begin
         write_cfg(1'b1, 1'b1, r);
         check("R3 request set", req_bit, 1'b1);
         fstart();
         check($sformatf("R4 rate %0d single pass", r), pass_en, 1'b1);
         check($sformatf("R3 rate %0d req cleared", r), req_bit, 1'b0);
         check($sformatf("R3 rate %0d clr pulse", r), req_clr, 1'b1);
         check($sformatf("R2 rate %0d active", r), cap_active, 1'b1);
         body();
         check("R3 clr pulse one cycle", req_clr, 1'b0);
         fend();
         check($sformatf("R4 rate %0d end pulse", r), cap_end, 1'b1);
         check($sformatf("R4 rate %0d inactive", r), cap_active, 1'b0);
         fstart();
         check($sformatf("R4 rate %0d second frame", r), pass_en, 1'b0);
         body(); fend();
      end

      // R8: request written mid-frame
      fstart();
      write_cfg(1'b1, 1'b0, 0);
      body();
      check("R8 mid-frame pass", pass_en, 1'b0);
      check("R8 mid-frame active", cap_active, 1'b0);
      fend();
      check("R8 no end pulse", cap_end, 1'b0);
      fstart();
      check("R8 next frame passed", pass_en, 1'b1);

      // R9: pipe enable drop inside a passed frame
      @(negedge clk); pipe_en = 1'b0;
      @(negedge clk);
      check("R9 pass dropped", pass_en, 1'b0);
      check("R9 active dropped", cap_active, 1'b0);
      pipe_en = 1'b1;
      body();
      check("R9 stays dropped", pass_en, 1'b0);
      fend();
      check("R9 no end pulse", cap_end, 1'b0);
      fstart();
      check("R1 restart at frame start", pass_en, 1'b1);
      check("R1 restart active", cap_active, 1'b1);
      body(); fend();
      write_cfg(1'b0, 1'b0, 0);
      body();

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule